// File: doc/BRIEF.md
# Transmit Time Stamp Offset Adder

This block produces the time stamp carried by an outgoing isochronous packet. On a request strobe it adds a programmed delay to the current bus cycle timer and registers the sum. The cycle timer is not a plain binary number. It is a mixed-radix value made of three fields:

- a seconds field;
- a cycle count that wraps at 8000;
- a cycle offset that wraps at 3072.

The adder therefore carries between fields at those limits and does not use binary overflow.

The delay value holds only a cycle count and a cycle offset. If either of its fields is out of range, the request is refused: an error pulse is raised and the last good stamp is kept. The result appears one clock after the strobe and is marked by a one-cycle valid pulse.

Top module: `ts_offset_adder`

## Requirements
- R1: While reset is asserted and after it is released, `stamp_o` is 0 and both `valid_o` and `err_o` are 0, until the first request is sampled.
- R2: Field layout and offset digit.
  - Layout of `timer_i` and `stamp_o`: bits 31:25 hold the seconds, bits 24:12 hold the cycle count and bits 11:0 hold the cycle offset.
  - Layout of `ofs_cfg_i`: bits 24:12 hold the count delay and bits 11:0 hold the offset delay.
  - The stamp's offset field is (timer offset + offset delay) mod 3072. A carry of one passes to the count field when the sum exceeds 3071.
- R3: The stamp's count field is (timer count + count delay + offset carry) mod 8000. A carry of one passes to the seconds field when the sum exceeds 7999.
- R4: The stamp's seconds field is (timer seconds + count carry) mod 128.
- R5: A request sampled at a rising edge drives `stamp_o` and `valid_o`=1 right after that edge. `valid_o` stays high for exactly one cycle per request.
- R6: A request whose offset delay exceeds 3071, or whose count delay exceeds 7999, makes `err_o`=1 for one cycle. In that case `valid_o` stays 0 and `stamp_o` keeps its previous value.
- R7: Without a request, `valid_o` and `err_o` are 0 on the next cycle and `stamp_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, one stamp per cycle high |
| timer_i | input | 32 | Current cycle timer (seconds, count, offset) |
| ofs_cfg_i | input | 25 | Programmed delay (count, offset) |
| stamp_o | output | 32 | Registered transmit time stamp |
| valid_o | output | 1 | One-cycle pulse marking a new stamp |
| err_o | output | 1 | One-cycle pulse marking a refused delay |

## Verification
The range assertions on the output fields assume that the cycle timer input is itself well formed: offset below 3072 and count below 8000. The stimulus sweeps only timer values inside those limits, including both edges of each field. Out-of-range values are applied only to the delay input, where the block must detect them itself. The latency and idle assertions assume that `req_i` is low during reset, and the bench holds it low until reset is released.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
    parameter int unsigned SEC_W_DEF   = 7;
    parameter int unsigned CNT_W_DEF   = 13;
    parameter int unsigned OFS_W_DEF   = 12;
    parameter int unsigned CNT_LIM_DEF = 8000;
    parameter int unsigned OFS_LIM_DEF = 3072;
endpackage

// File: rtl/tsa_digit_add.sv
module tsa_digit_add #(
    parameter int unsigned W   = 12,
    parameter int unsigned LIM = 3072
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    localparam logic [W:0] LIM_V = (W+1)'(LIM);

    logic [W:0] raw;
    logic [W:0] wrapped;

    always_comb begin
        raw     = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        wrapped = raw - LIM_V;
        cout_o  = (raw >= LIM_V);
        sum_o   = cout_o ? wrapped[W-1:0] : raw[W-1:0];
    end
endmodule

// File: rtl/tsa_range_chk.sv
module tsa_range_chk #(
    parameter int unsigned W   = 12,
    parameter int unsigned LIM = 3072
) (
    input  logic [W-1:0] val_i,
    output logic         ok_o
);
    localparam logic [W:0] LIM_V = (W+1)'(LIM);

    always_comb ok_o = ({1'b0, val_i} < LIM_V);
endmodule

// File: rtl/ts_offset_adder.sv
module ts_offset_adder
    import tsa_pkg::*;
#(
    parameter int unsigned SEC_W   = SEC_W_DEF,
    parameter int unsigned CNT_W   = CNT_W_DEF,
    parameter int unsigned OFS_W   = OFS_W_DEF,
    parameter int unsigned CNT_LIM = CNT_LIM_DEF,
    parameter int unsigned OFS_LIM = OFS_LIM_DEF
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_i,
    input  logic [SEC_W+CNT_W+OFS_W-1:0]   timer_i,
    input  logic [CNT_W+OFS_W-1:0]         ofs_cfg_i,
    output logic [SEC_W+CNT_W+OFS_W-1:0]   stamp_o,
    output logic                           valid_o,
    output logic                           err_o
);
    localparam int unsigned TS_W  = SEC_W + CNT_W + OFS_W;
    localparam int unsigned CNT_LO = OFS_W;
    localparam int unsigned SEC_LO = OFS_W + CNT_W;

    typedef struct packed {
        logic [TS_W-1:0] stamp;
        logic            vld;
        logic            err;
    } state_t;

    state_t st_d, st_q;

    // field split
    logic [OFS_W-1:0] t_ofs, d_ofs, s_ofs;
    logic [CNT_W-1:0] t_cnt, d_cnt, s_cnt;
    logic [SEC_W-1:0] t_sec, s_sec;
    logic             c_ofs, c_cnt;
    logic             ok_ofs, ok_cnt;

    assign t_ofs = timer_i[OFS_W-1:0];
    assign t_cnt = timer_i[SEC_LO-1:CNT_LO];
    assign t_sec = timer_i[TS_W-1:SEC_LO];
    assign d_ofs = ofs_cfg_i[OFS_W-1:0];
    assign d_cnt = ofs_cfg_i[SEC_LO-1:CNT_LO];

    tsa_digit_add #(.W(OFS_W), .LIM(OFS_LIM)) u_ofs_add (
        .a_i(t_ofs), .b_i(d_ofs), .cin_i(1'b0), .sum_o(s_ofs), .cout_o(c_ofs)
    );

    tsa_digit_add #(.W(CNT_W), .LIM(CNT_LIM)) u_cnt_add (
        .a_i(t_cnt), .b_i(d_cnt), .cin_i(c_ofs), .sum_o(s_cnt), .cout_o(c_cnt)
    );

    tsa_range_chk #(.W(OFS_W), .LIM(OFS_LIM)) u_ofs_chk (
        .val_i(d_ofs), .ok_o(ok_ofs)
    );

    tsa_range_chk #(.W(CNT_W), .LIM(CNT_LIM)) u_cnt_chk (
        .val_i(d_cnt), .ok_o(ok_cnt)
    );

    // seconds wrap in plain binary
    assign s_sec = t_sec + {{(SEC_W-1){1'b0}}, c_cnt};

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.err = 1'b0;
        if (req_i) begin
            if (ok_ofs && ok_cnt) begin
                st_d.stamp = {s_sec, s_cnt, s_ofs};
                st_d.vld   = 1'b1;
            end else begin
                st_d.err   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stamp_o = st_q.stamp;
    assign valid_o = st_q.vld;
    assign err_o   = st_q.err;

    // R2: offset field in range (timer input assumed well formed)
    a_r2_ofs_range: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ({1'b0, stamp_o[OFS_W-1:0]} < (OFS_W+1)'(OFS_LIM)));

    // R3: count field in range
    a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ({1'b0, stamp_o[SEC_LO-1:CNT_LO]} < (CNT_W+1)'(CNT_LIM)));

    // R5: a valid pulse follows a request
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(req_i));

    // R6: refusal keeps stamp and never validates
    a_r6_reject: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!valid_o && $stable(stamp_o) && $past(req_i)));

    // R7: idle cycle leaves outputs quiet
    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_i) |-> (!valid_o && !err_o && $stable(stamp_o)));
endmodule

// File: tb/test_ts_offset_adder.sv
`timescale 1ns/1ps
module test_ts_offset_adder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [31:0] timer_i = '0;
    logic [24:0] ofs_cfg_i = '0;
    logic [31:0] stamp_o;
    logic        valid_o, err_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ts_offset_adder i_ts_offset_adder (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .timer_i(timer_i),
        .ofs_cfg_i(ofs_cfg_i), .stamp_o(stamp_o), .valid_o(valid_o), .err_o(err_o)
    );

    localparam longint MOD = 64'd128 * 64'd8000 * 64'd3072;

    function automatic logic [31:0] mk(input int s, input int c, input int o);
        return {s[6:0], c[12:0], o[11:0]};
    endfunction

    function automatic logic [31:0] expect_stamp(input int s, input int c, input int o,
                                                 input int dc, input int dofs);
        longint lin, dl;
        int rs, rc, ro;
        lin = (longint'(s) * 8000 + c) * 3072 + o;
        dl  = longint'(dc) * 3072 + dofs;
        lin = (lin + dl) % MOD;
        ro  = int'(lin % 3072);
        rc  = int'((lin / 3072) % 8000);
        rs  = int'(lin / (3072 * 8000));
        return mk(rs, rc, ro);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // apply one request; results sampled at the following negedge
    task automatic do_req(input logic [31:0] t, input logic [24:0] d);
        @(negedge clk);
        timer_i = t; ofs_cfg_i = d; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int so[5] = '{0, 1, 1535, 3070, 3071};
        int sc[5] = '{0, 1, 3999, 7998, 7999};
        int ss[3] = '{0, 5, 127};
        logic [31:0] prev, e;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(stamp_o == 0 && !valid_o && !err_o, "R1", {stamp_o, valid_o, err_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stamp_o == 0 && !valid_o && !err_o, "R1", {stamp_o, valid_o, err_o}, 0);

        // R2 R3 R4 R5: sweep field corners of timer and delay
        foreach (ss[a]) foreach (sc[b]) foreach (so[c]) foreach (sc[f]) foreach (so[g]) begin
            do_req(mk(ss[a], sc[b], so[c]), {sc[f][12:0], so[g][11:0]});
            e = expect_stamp(ss[a], sc[b], so[c], sc[f], so[g]);
            chk(valid_o && !err_o, "R5", {valid_o, err_o}, 2'b10);
            chk(stamp_o[11:0] == e[11:0], "R2", stamp_o[11:0], e[11:0]);
            chk(stamp_o[24:12] == e[24:12], "R3", stamp_o[24:12], e[24:12]);
            chk(stamp_o[31:25] == e[31:25], "R4", stamp_o[31:25], e[31:25]);
        end

        // R5 and R7: pulse lasts one cycle, idle keeps stamp
        prev = stamp_o;
        @(negedge clk);
        chk(!valid_o && !err_o, "R5", valid_o, 0);
        chk(stamp_o == prev, "R7", stamp_o, prev);
        timer_i = mk(3, 4, 5); ofs_cfg_i = 25'h1;
        @(negedge clk);
        chk(!valid_o && !err_o && stamp_o == prev, "R7", stamp_o, prev);

        // back-to-back requests each produce a stamp
        @(negedge clk);
        timer_i = mk(1, 2, 3); ofs_cfg_i = {13'd0, 12'd1}; req_i = 1'b1;
        @(negedge clk);
        chk(valid_o && stamp_o == mk(1, 2, 4), "R5", stamp_o, mk(1, 2, 4));
        timer_i = mk(1, 2, 3071); ofs_cfg_i = {13'd0, 12'd1};
        @(negedge clk);
        req_i = 1'b0;
        chk(valid_o && stamp_o == mk(1, 3, 0), "R2", stamp_o, mk(1, 3, 0));

        // R6: out-of-range delays refused
        prev = stamp_o;
        do_req(mk(2, 2, 2), {13'd0, 12'd3072});
        chk(err_o && !valid_o && stamp_o == prev, "R6", {stamp_o, valid_o, err_o}, {prev, 2'b01});
        do_req(mk(2, 2, 2), {13'd8000, 12'd0});
        chk(err_o && !valid_o && stamp_o == prev, "R6", {stamp_o, valid_o, err_o}, {prev, 2'b01});
        do_req(mk(2, 2, 2), {13'h1FFF, 12'hFFF});
        chk(err_o && !valid_o && stamp_o == prev, "R6", {stamp_o, valid_o, err_o}, {prev, 2'b01});
        @(negedge clk);
        chk(!err_o, "R6", err_o, 0);
        // largest legal delay still accepted
        do_req(mk(127, 7999, 3071), {13'd7999, 12'd3071});
        e = expect_stamp(127, 7999, 3071, 7999, 3071);
        chk(valid_o && !err_o && stamp_o == e, "R6", stamp_o, e);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule